// File: doc/BRIEF.md
# Instruction Miss Line-Fill Buffer

This block manages the refill of one instruction-cache line after a fetch misses. It starts a line read on a simple bus port and names the missed word as the first word wanted. Words then come back one per beat, in whatever order the responder chooses, and each carries its position in the line. Every returned word is written into a line-wide holding buffer at its position. The missed word is passed straight through to the fetch response in the cycle it lands, so the fetch does not wait for the rest of the line.

While the refill is running, fetches to the same line are answered from the buffer if their word has already arrived. Otherwise they are held and answered in the beat that brings their word. A fetch to any other line is held until the refill is finished. When the last word has been captured, the whole buffer is written to the cache array in a single strobe, but only for a cacheable refill. Only one refill is in flight at a time.

Top module: `linefill_buf`

## Requirements
- R1: After reset the block is idle with no words marked present: no bus request, no line write and no fetch response are produced, and a non-miss fetch gets no response.
- R2: A fetch with the miss flag set, presented while idle, raises the bus read request in that same cycle for exactly one cycle. The request carries the line address (fetch address bits [31:5]) and names as first word the fetch's word index (bits [4:2]). The fetch is held in that cycle.
- R3: In the cycle a word returns whose index matches a pending fetch to the refill line, that fetch is answered in the same cycle with the returned data. This holds whatever order the words come back in.
- R4: Each returned word is stored at its returned index. In the line write, word i appears at bits [32i+31:32i].
- R5: A fetch to the refill line whose word has already been captured is answered in the same cycle from the buffer.
- R6: A fetch to the refill line whose word has not yet arrived is held with no response until the beat that delivers that word.
- R7: During a refill or its line write, a fetch to a different line is held. Once the block is idle again, the same fetch starts a new refill.
- R8: For a cacheable refill, the line write strobe is raised for exactly one cycle, the cycle after the last of the eight words is captured. It carries the refill line address.
- R9: A non-cacheable refill uses the same buffer and bypass, but never raises the line write strobe.
- R10: While a refill or its line write is in progress, no new bus read request is issued, even for a missing fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_valid | input | 1 | Fetch request present |
| fetch_addr | input | AW | Fetch byte address |
| fetch_miss | input | 1 | Cache lookup for this fetch missed |
| fetch_cacheable | input | 1 | Region of the missing fetch may be cached |
| fetch_hold | output | 1 | Fetch must be held this cycle |
| rsp_valid | output | 1 | Instruction word delivered this cycle |
| rsp_data | output | DW | Delivered instruction word |
| bus_rd_valid | output | 1 | Line read request, one cycle |
| bus_rd_line | output | AW-5 | Line address of the read |
| bus_rd_first | output | 3 | Word index to return first |
| bus_ret_valid | input | 1 | Returned word present |
| bus_ret_idx | input | 3 | Index of the returned word |
| bus_ret_data | input | DW | Returned word |
| line_wr_en | output | 1 | Write the full line into the cache array |
| line_wr_line | output | AW-5 | Line address of the write |
| line_wr_data | output | WORDS*DW | Whole line, word i at bits [32i+31:32i] |

## Verification
The hardest case to reach is a fetch that arrives while its word is still outstanding and is then answered by the bypass in the beat that delivers it. Close to it is a word landing in the very last beat, which brings a response and the end of the refill together. The stimulus changes the fetch address part-way through each refill and has the responder return words out of order, with the missed word sometimes late. It also holds a fetch to a foreign line across the line-write cycle, so the hand-off from refill to a new request is exercised.

// File: rtl/linefill_buf.sv
module linefill_buf #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int WORDS = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  fetch_valid,
  input  logic [AW-1:0]         fetch_addr,
  input  logic                  fetch_miss,
  input  logic                  fetch_cacheable,
  output logic                  fetch_hold,
  output logic                  rsp_valid,
  output logic [DW-1:0]         rsp_data,
  output logic                  bus_rd_valid,
  output logic [AW-6:0]         bus_rd_line,
  output logic [2:0]            bus_rd_first,
  input  logic                  bus_ret_valid,
  input  logic [2:0]            bus_ret_idx,
  input  logic [DW-1:0]         bus_ret_data,
  output logic                  line_wr_en,
  output logic [AW-6:0]         line_wr_line,
  output logic [WORDS*DW-1:0]   line_wr_data
);
  localparam int IW = $clog2(WORDS);
  localparam int OW = $clog2(DW/8);
  localparam int LW = AW - IW - OW;

  typedef enum logic [1:0] {S_IDLE, S_FILL, S_WRITE} state_t;

  state_t            st_q;
  logic [DW-1:0]     buf_q [WORDS];
  logic [WORDS-1:0]  vld_q;
  logic [WORDS-1:0]  vld_nxt;
  logic [LW-1:0]     line_q;
  logic              cach_q;

  wire [IW-1:0] f_idx  = fetch_addr[OW +: IW];
  wire [LW-1:0] f_line = fetch_addr[AW-1 -: LW];
  wire          busy   = (st_q != S_IDLE);
  wire          take   = bus_ret_valid && (st_q == S_FILL);
  wire          same   = busy && (f_line == line_q);
  wire          have   = vld_q[f_idx];
  wire          land   = take && (bus_ret_idx == f_idx);

  assign rsp_valid    = fetch_valid && same && (have || land);
  assign rsp_data     = have ? buf_q[f_idx] : bus_ret_data;
  assign bus_rd_valid = fetch_valid && fetch_miss && !busy;
  assign bus_rd_line  = f_line;
  assign bus_rd_first = f_idx;
  assign fetch_hold   = fetch_valid && (bus_rd_valid || (busy && !rsp_valid));
  assign line_wr_en   = (st_q == S_WRITE) && cach_q;
  assign line_wr_line = line_q;
  assign vld_nxt      = vld_q | (take ? (WORDS'(1) << bus_ret_idx) : '0);

  for (genvar i = 0; i < WORDS; i++) begin : g_pack
    assign line_wr_data[i*DW +: DW] = buf_q[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      vld_q  <= '0;
      line_q <= '0;
      cach_q <= 1'b0;
    end else begin
      case (st_q)
        S_IDLE: if (bus_rd_valid) begin
          st_q   <= S_FILL;
          line_q <= f_line;
          cach_q <= fetch_cacheable;
          vld_q  <= '0;
        end
        S_FILL: begin
          vld_q <= vld_nxt;
          if (&vld_nxt) st_q <= S_WRITE;
        end
        default: begin
          st_q  <= S_IDLE;
          vld_q <= '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (take) buf_q[bus_ret_idx] <= bus_ret_data;
  end
endmodule

// File: rtl/linefill_chk.sv
module linefill_chk #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fetch_valid,
  input logic          fetch_hold,
  input logic          rsp_valid,
  input logic [DW-1:0] rsp_data,
  input logic          bus_rd_valid,
  input logic          bus_ret_valid,
  input logic [2:0]    bus_ret_idx,
  input logic [DW-1:0] bus_ret_data,
  input logic          line_wr_en,
  input logic          same,
  input logic          have,
  input logic [2:0]    f_idx
);
  AST_BYPASS_NOW: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && same && !have && bus_ret_valid && bus_ret_idx == f_idx)
      |-> (rsp_valid && rsp_data == bus_ret_data)); // R3
  AST_REQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd_valid |-> (fetch_hold && !rsp_valid)); // R2
  AST_ONE_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd_valid |=> !bus_rd_valid); // R10
  AST_WR_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    line_wr_en |-> $past(bus_ret_valid)); // R8
  AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    line_wr_en |=> !line_wr_en); // R8
endmodule

bind linefill_buf linefill_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/linefill_buf_tb.sv
module linefill_buf_tb;
  logic clk = 0;
  logic rst_n = 0;
  always #10 clk = ~clk;

  logic         fetch_valid = 0, fetch_miss = 0, fetch_cacheable = 0;
  logic [31:0]  fetch_addr = '0;
  logic         bus_ret_valid = 0;
  logic [2:0]   bus_ret_idx = '0;
  logic [31:0]  bus_ret_data = '0;
  logic         fetch_hold, rsp_valid, bus_rd_valid, line_wr_en;
  logic [31:0]  rsp_data;
  logic [26:0]  bus_rd_line, line_wr_line;
  logic [2:0]   bus_rd_first;
  logic [255:0] line_wr_data;

  linefill_buf u_dut (.*);

  int vectors = 0, errors = 0;
  int m_st = 0;
  logic [26:0] m_line = '0;
  logic        m_cach = 0;
  logic [7:0]  m_have = '0;
  logic [31:0] m_buf [8];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin m_st = 0; m_have = '0; end
    else if (m_st == 0) begin
      if (fetch_valid && fetch_miss) begin
        m_st = 1; m_line = fetch_addr[31:5]; m_cach = fetch_cacheable; m_have = '0;
      end
    end else if (m_st == 1) begin
      if (bus_ret_valid) begin m_buf[bus_ret_idx] = bus_ret_data; m_have[bus_ret_idx] = 1'b1; end
      if (m_have == 8'hFF) m_st = 2;
    end else begin m_st = 0; m_have = '0; end
  end

  task automatic cmp(string tag, string nm, logic [255:0] act, logic [255:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, nm, act, exp, $time);
    end
  endtask

  task automatic step(input logic fv, input logic [31:0] a, input logic ms, input logic ca,
                      input logic rv, input logic [2:0] ri, input logic [31:0] rd);
    @(negedge clk);
    fetch_valid = fv; fetch_addr = a; fetch_miss = ms; fetch_cacheable = ca;
    bus_ret_valid = rv; bus_ret_idx = ri; bus_ret_data = rd;
    #4;
    begin
      bit busy = (m_st != 0);
      bit same = busy && (a[31:5] == m_line);
      bit have = m_have[a[4:2]];
      bit land = rv && m_st == 1 && ri == a[4:2];
      bit e_rsp = fv && same && (have || land);
      bit e_req = fv && ms && !busy;
      bit e_hold = fv && (e_req || (busy && !e_rsp));
      bit e_wr = (m_st == 2) && m_cach;
      string t;
      if (!rst_n) t = "R1";
      else if (e_rsp) t = have ? "R5" : "R3";
      else if (fv && same) t = "R6";
      else if (fv && busy) t = "R7";
      else t = "R1";
      cmp(t, "rsp_valid", rsp_valid, e_rsp);
      if (e_rsp) cmp(t, "rsp_data", rsp_data, have ? m_buf[a[4:2]] : rd);
      cmp(t, "fetch_hold", fetch_hold, e_hold);
      cmp(busy ? "R10" : "R2", "bus_rd_valid", bus_rd_valid, e_req);
      if (e_req) begin
        cmp("R2", "bus_rd_line", bus_rd_line, a[31:5]);
        cmp("R2", "bus_rd_first", bus_rd_first, a[4:2]);
      end
      cmp(m_cach ? "R8" : "R9", "line_wr_en", line_wr_en, e_wr);
      if (e_wr) begin
        cmp("R8", "line_wr_line", line_wr_line, m_line);
        for (int i = 0; i < 8; i++)
          cmp("R4", "line_wr_data word", line_wr_data[i*32 +: 32], m_buf[i]);
      end
    end
  endtask

  function automatic logic [31:0] wd(logic [26:0] ln, int i);
    return {ln[11:0], 4'hA, 8'(i), 8'h5C};
  endfunction

  task automatic fill(logic [26:0] ln, logic ca, int first, logic [2:0] order [8], logic [2:0] alt);
    step(1, {ln, 3'(first), 2'b0}, 1, ca, 0, 0, 0);
    for (int k = 0; k < 8; k++) begin
      logic [31:0] fa;
      if (k < 3) fa = {ln, 3'(first), 2'b0};
      else if (k < 6) fa = {ln, alt, 2'b0};
      else fa = {ln + 27'd1, 3'd0, 2'b0};
      step(1, fa, 1, 1, 1, order[k], wd(ln, order[k]));
    end
    step(1, {ln + 27'd1, 3'd0, 2'b0}, 1, 1, 0, 0, 0);
    step(1, {ln, alt, 2'b0}, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    logic [2:0] o1 [8] = '{3'd5, 3'd6, 3'd7, 3'd0, 3'd1, 3'd2, 3'd3, 3'd4};
    logic [2:0] o2 [8] = '{3'd3, 3'd6, 3'd1, 3'd0, 3'd7, 3'd2, 3'd5, 3'd4};
    logic [2:0] o3 [8] = '{3'd2, 3'd4, 3'd0, 3'd7, 3'd6, 3'd1, 3'd3, 3'd5};
    step(0, 0, 0, 0, 0, 0, 0);
    step(1, 32'h1000, 1, 1, 0, 0, 0);
    rst_n = 1;
    step(1, 32'h1000, 0, 0, 0, 0, 0);
    fill(27'h0040, 1, 5, o1, 3'd2);
    fill(27'h0123, 1, 0, o2, 3'd5);
    fill(27'h0456, 0, 4, o3, 3'd7);
    fill(27'h0789, 1, 7, o2, 3'd4);
    step(1, 32'hABC0, 1, 1, 0, 0, 0);
    step(1, 32'hABC4, 1, 1, 1, 3'd1, 32'hFEED0001);
    step(1, 32'hABC4, 1, 1, 1, 3'd1, 32'hFEED0002);
    rst_n = 0;
    step(1, 32'hABC4, 0, 0, 0, 0, 0);
    rst_n = 1;
    step(1, 32'hABC4, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule